// File: doc/BRIEF.md
# Clock source control register

This block holds the software-visible control and status for a microcontroller's system clock. A two-bit select field names which oscillator should drive the core: the primary oscillator, a low-frequency secondary oscillator or the internal oscillator block. A third writable bit picks between full sleep and an idle mode when the core executes a sleep request. Three read-only flags report which source is actually driving the clock. Each flag is qualified by that source's own readiness condition and is held off while a source change is in progress.

A write that changes the select field takes effect on the next clock. A busy indication then covers a fixed switch interval, and all three status flags read zero while it lasts. The primary source is only reported as running once an internal start-up timer has counted a parameterised number of primary-clock ticks. That timer restarts whenever the primary oscillator is turned off. A sleep request becomes a one-cycle sleep or idle pulse. It is dropped when the secondary source is selected but the secondary oscillator is not enabled.

The oscillators and the glitch-free clock multiplexer sit outside this block. They consume `srcSel`, `enterSleep` and `enterIdle`, and they supply the readiness inputs.

Top module: `clk_src_ctl`

## Requirements
- R1: While `rstN` is low, `srcSel`, the idle-enable bit, all three status flags, `swBusy`, `enterSleep` and `enterIdle` are zero, and the start-up timer is cleared.
- R2: The register reads as bits[1:0] select, bit 2 idle-enable, bit 3 primary-running, bit 4 internal-running, bit 5 secondary-running, and bits 7:6 zero. A write with `wrEn` loads bits[1:0] and bit 2 on the next clock. `rdData` shows the register while `rdEn` is high and is zero otherwise.
- R3: Written values in bits 7:3 have no effect. The status flags cannot be set or cleared from the bus.
- R4: A write whose bits[1:0] differ from the current select raises `swBusy` on the next clock and holds it for exactly SWITCH_CYCLES cycles. A write of the same select value leaves `swBusy` low.
- R5: The start-up timer counts `priTick` pulses while `priOscOn` is high and clears when `priOscOn` is low. It is complete after OST_CYCLES ticks (default 1024).
- R6: `priRun` is set one clock after select is 00, the timer is complete and no switch is in progress.
- R7: `intRun` is set one clock after select is 10 or 11, `intStable` is high and no switch is in progress.
- R8: `secRun` is set one clock after select is 01, `secOscEn` is high and no switch is in progress.
- R9: At most one status flag is set at a time. All flags are zero on the clock after any cycle with `swBusy` high.
- R10: A `sleepReq` pulse gives a one-cycle `enterSleep` on the next clock when idle-enable is 0. It gives a one-cycle `enterIdle` when idle-enable is 1.
- R11: A `sleepReq` while select is 01 and `secOscEn` is low produces neither `enterSleep` nor `enterIdle`.
- R12: `srcSel` always equals the select field of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdEn | input | 1 | Register read strobe |
| rdData | output | 8 | Register read data, zero when not reading |
| priOscOn | input | 1 | Primary oscillator is powered and running |
| priTick | input | 1 | One pulse per primary oscillator cycle |
| intStable | input | 1 | Internal oscillator block is stable |
| secOscEn | input | 1 | Secondary oscillator is enabled |
| sleepReq | input | 1 | Core executed a sleep request |
| srcSel | output | 2 | Requested clock source code |
| swBusy | output | 1 | Source switch interval in progress |
| priRun | output | 1 | Primary source is driving the clock |
| intRun | output | 1 | Internal block is driving the clock |
| secRun | output | 1 | Secondary source is driving the clock |
| enterSleep | output | 1 | One-cycle pulse: enter full sleep |
| enterIdle | output | 1 | One-cycle pulse: enter idle mode |

## Verification
The main status function is driven with a sequence of select codes, each paired with a different mix of `secOscEn` and `intStable`. This separates a flag that follows its source from one that wrongly ignores its readiness input, and it covers both internal codes 10 and 11. Some writes also set the read-only bits or bits 7:6, so a readback that differs from the expected value shows leakage from the bus into the flags. Directed sequences count the exact busy window and the start-up timer threshold tick by tick. They also cover the four sleep cases formed by idle-enable and secondary readiness, and reset applied mid-operation.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  localparam logic [1:0] SEL_PRI = 2'b00;
  localparam logic [1:0] SEL_SEC = 2'b01;

  // register bit positions
  localparam int IDLE_BIT = 2;
  localparam int PRI_BIT  = 3;
  localparam int INT_BIT  = 4;
  localparam int SEC_BIT  = 5;

  typedef struct packed {
    logic loadSel;
    logic loadIdle;
    logic switching;
    logic ostDone;
    logic goSleep;
    logic goIdle;
  } ctlStrobe_t;

  function automatic logic isInternal(input logic [1:0] sel);
    return sel[1];
  endfunction

endpackage

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int OST_CYCLES    = 1024,
  parameter int SWITCH_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [1:0] curSel,
  input  logic       curIdle,
  input  logic       priOscOn,
  input  logic       priTick,
  input  logic       secOscEn,
  input  logic       sleepReq,
  output ctlStrobe_t strobe
);

  localparam int OST_W = $clog2(OST_CYCLES + 1);
  localparam int SW_W  = $clog2(SWITCH_CYCLES + 1);
  localparam logic [OST_W-1:0] OST_LAST = OST_W'(OST_CYCLES);
  localparam logic [SW_W-1:0]  SW_LOAD  = SW_W'(SWITCH_CYCLES);

  logic [OST_W-1:0] ostCnt;
  logic [SW_W-1:0]  swCnt;
  logic             ostDone;
  logic             switchStart;
  logic             sleepBlocked;

  assign ostDone      = (ostCnt == OST_LAST);
  assign switchStart  = wrEn && (wrSel != curSel);
  assign sleepBlocked = (curSel == SEL_SEC) && !secOscEn;

  // start-up timer on the primary oscillator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ostCnt <= '0;
    end else if (!priOscOn) begin
      ostCnt <= '0;
    end else if (priTick && !ostDone) begin
      ostCnt <= ostCnt + 1'b1;
    end
  end

  // switch interval counter, reloaded by every changing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swCnt <= '0;
    end else if (switchStart) begin
      swCnt <= SW_LOAD;
    end else if (swCnt != '0) begin
      swCnt <= swCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.loadSel   = wrEn;
    strobe.loadIdle  = wrEn;
    strobe.switching = (swCnt != '0);
    strobe.ostDone   = ostDone;
    strobe.goSleep   = sleepReq && !curIdle && !sleepBlocked;
    strobe.goIdle    = sleepReq &&  curIdle && !sleepBlocked;
  end

endmodule

// File: rtl/clk_src_dp.sv
module clk_src_dp
  import clk_src_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic [2:0] wrLow,
  input  logic       rdEn,
  input  logic       intStable,
  input  logic       secOscEn,
  output logic [1:0] clkSel,
  output logic       idleEn,
  output logic       priRunQ,
  output logic       intRunQ,
  output logic       secRunQ,
  output logic       sleepPulse,
  output logic       idlePulse,
  output logic [7:0] rdData
);

  logic priCond;
  logic intCond;
  logic secCond;

  assign priCond = !strobe.switching && (clkSel == SEL_PRI) && strobe.ostDone;
  assign intCond = !strobe.switching && isInternal(clkSel) && intStable;
  assign secCond = !strobe.switching && (clkSel == SEL_SEC) && secOscEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel <= SEL_PRI;
      idleEn <= 1'b0;
    end else begin
      if (strobe.loadSel)  clkSel <= wrLow[1:0];
      if (strobe.loadIdle) idleEn <= wrLow[IDLE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priRunQ <= 1'b0;
      intRunQ <= 1'b0;
      secRunQ <= 1'b0;
    end else begin
      priRunQ <= priCond;
      intRunQ <= intCond;
      secRunQ <= secCond;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepPulse <= 1'b0;
      idlePulse  <= 1'b0;
    end else begin
      sleepPulse <= strobe.goSleep;
      idlePulse  <= strobe.goIdle;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      rdData[1:0]      = clkSel;
      rdData[IDLE_BIT] = idleEn;
      rdData[PRI_BIT]  = priRunQ;
      rdData[INT_BIT]  = intRunQ;
      rdData[SEC_BIT]  = secRunQ;
    end
  end

endmodule

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
  import clk_src_pkg::*;
#(
  parameter int OST_CYCLES    = 1024,
  parameter int SWITCH_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData,
  input  logic       priOscOn,
  input  logic       priTick,
  input  logic       intStable,
  input  logic       secOscEn,
  input  logic       sleepReq,
  output logic [1:0] srcSel,
  output logic       swBusy,
  output logic       priRun,
  output logic       intRun,
  output logic       secRun,
  output logic       enterSleep,
  output logic       enterIdle
);

  ctlStrobe_t strobe;
  logic [1:0] clkSel;
  logic       idleEn;
  logic       unusedWrBits;

  // bits 7:3 carry read-only or reserved fields and are dropped here
  assign unusedWrBits = |wrData[7:3];

  clk_src_ctrl #(
    .OST_CYCLES   (OST_CYCLES),
    .SWITCH_CYCLES(SWITCH_CYCLES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrData[1:0]),
    .curSel   (clkSel),
    .curIdle  (idleEn),
    .priOscOn (priOscOn),
    .priTick  (priTick),
    .secOscEn (secOscEn),
    .sleepReq (sleepReq),
    .strobe   (strobe)
  );

  clk_src_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrLow     (wrData[2:0]),
    .rdEn      (rdEn),
    .intStable (intStable),
    .secOscEn  (secOscEn),
    .clkSel    (clkSel),
    .idleEn    (idleEn),
    .priRunQ   (priRun),
    .intRunQ   (intRun),
    .secRunQ   (secRun),
    .sleepPulse(enterSleep),
    .idlePulse (enterIdle),
    .rdData    (rdData)
  );

  assign srcSel = clkSel;
  assign swBusy = strobe.switching;

endmodule

// File: rtl/clk_src_ctl_chk.sv
module clk_src_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic       priOscOn,
  input logic       priTick,
  input logic       intStable,
  input logic       secOscEn,
  input logic       sleepReq,
  input logic [1:0] srcSel,
  input logic       swBusy,
  input logic       priRun,
  input logic       intRun,
  input logic       secRun,
  input logic       enterSleep,
  input logic       enterIdle
);

  // R4: a changing write opens the switch window on the next clock
  a_r4_busy_after_change: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrData[1:0] != srcSel)) |=> swBusy);

  // R9: status flags are mutually exclusive
  a_r9_flags_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({priRun, intRun, secRun}));

  // R9: no flag survives a cycle spent switching
  a_r9_quiet_switch: assert property (@(posedge clk) disable iff (!rstN)
    swBusy |=> (!priRun && !intRun && !secRun));

  // R8: secondary flag only follows a secondary select with the oscillator enabled
  a_r8_sec_qualified: assert property (@(posedge clk) disable iff (!rstN)
    secRun |-> ($past(srcSel) == 2'b01 && $past(secOscEn)));

  // R10: an accepted sleep request yields exactly one mode pulse
  a_r10_sleep_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && srcSel != 2'b01) |=> (enterSleep != enterIdle));

  // R11: secondary select without an enabled oscillator blocks the request
  a_r11_reject: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && srcSel == 2'b01 && !secOscEn) |=> (!enterSleep && !enterIdle));

  // R2: nothing is driven onto the read bus when not reading
  a_r2_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == 8'h00));

endmodule

bind clk_src_ctl clk_src_ctl_chk chk_i (.*);

// File: tb/clk_src_ctl_tb_top.sv
module clk_src_ctl_tb_top;

  localparam int OST   = 1024;
  localparam int SW    = 5;
  localparam int NVEC  = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [7:0] wrData;
  logic       rdEn;
  logic [7:0] rdData;
  logic       priOscOn;
  logic       priTick;
  logic       intStable;
  logic       secOscEn;
  logic       sleepReq;
  logic [1:0] srcSel;
  logic       swBusy;
  logic       priRun;
  logic       intRun;
  logic       secRun;
  logic       enterSleep;
  logic       enterIdle;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  clk_src_ctl #(.OST_CYCLES(OST), .SWITCH_CYCLES(SW)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .priOscOn(priOscOn), .priTick(priTick),
    .intStable(intStable), .secOscEn(secOscEn), .sleepReq(sleepReq),
    .srcSel(srcSel), .swBusy(swBusy), .priRun(priRun), .intRun(intRun),
    .secRun(secRun), .enterSleep(enterSleep), .enterIdle(enterIdle)
  );

  // {write data, secOscEn, intStable, expected readback}
  // readback: [1:0] select, [2] idle, [3] pri, [4] int, [5] sec
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h00, 1'b0, 1'b0, 8'h08},   // R6 primary running
    {8'h02, 1'b0, 1'b1, 8'h12},   // R7 internal stable
    {8'h03, 1'b0, 1'b0, 8'h03},   // R7 internal code 11, not stable
    {8'h01, 1'b1, 1'b1, 8'h21},   // R8 secondary enabled
    {8'h01, 1'b0, 1'b1, 8'h01},   // R8 secondary disabled
    {8'h3C, 1'b1, 1'b1, 8'h0C},   // R3 flag bits written, idle set
    {8'h3A, 1'b1, 1'b1, 8'h12},   // R3 flag bits written, internal
    {8'hC6, 1'b1, 1'b0, 8'h06}    // R3 bits 7:6 ignored
  };

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] d);
    wrEn = 1'b1;
    wrData = d;
    step();
    wrEn = 1'b0;
    wrData = 8'h00;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = 8'h00; rdEn = 1'b1;
    priOscOn = 1'b0; priTick = 1'b0; intStable = 1'b0;
    secOscEn = 1'b0; sleepReq = 1'b0;
    step(3);
    // R1 reset state
    chk("R1 rdData", rdData, 8'h00);
    chk("R1 outputs", {4'b0, swBusy, enterSleep, enterIdle, 1'b0}, 8'h00);

    rstN = 1'b1;
    priOscOn = 1'b1;
    priTick = 1'b1;
    // R5/R6 start-up timer threshold
    step(OST);
    chk("R5 priRun before timer done", {7'b0, priRun}, 8'h00);
    step();
    chk("R6 priRun after timer done", {7'b0, priRun}, 8'h01);

    // table of patterns
    for (int v = 0; v < NVEC; v++) begin
      secOscEn  = VEC[v][9];
      intStable = VEC[v][8];
      regWrite(VEC[v][17:10]);
      chk("R12 srcSel", {6'b0, srcSel}, {6'b0, VEC[v][11:10]});
      step(SW + 2);
      chk($sformatf("R2 vector %0d", v), rdData, VEC[v][7:0]);
    end

    // R2 no read, zero bus
    rdEn = 1'b0;
    #1;
    chk("R2 rdEn low", rdData, 8'h00);
    rdEn = 1'b1;

    // R4 exact busy window: now select 10, write 00
    regWrite(8'h00);
    chk("R4 busy first cycle", {7'b0, swBusy}, 8'h01);
    step(SW - 1);
    chk("R4 busy last cycle", {7'b0, swBusy}, 8'h01);
    chk("R9 flags clear while busy", {5'b0, priRun, intRun, secRun}, 8'h00);
    step();
    chk("R4 busy ended", {7'b0, swBusy}, 8'h00);
    chk("R9 flag still clear", {7'b0, priRun}, 8'h00);
    step();
    chk("R6 flag after window", {7'b0, priRun}, 8'h01);

    // R4 same-select write does not switch
    regWrite(8'h00);
    chk("R4 no switch on same select", {7'b0, swBusy}, 8'h00);

    // R10 sleep with idle-enable 0
    sleepReq = 1'b1;
    step();
    sleepReq = 1'b0;
    chk("R10 sleep pulse", {6'b0, enterSleep, enterIdle}, 8'h02);
    step();
    chk("R10 sleep pulse one cycle", {6'b0, enterSleep, enterIdle}, 8'h00);

    // R10 idle with idle-enable 1
    regWrite(8'h04);
    sleepReq = 1'b1;
    step();
    sleepReq = 1'b0;
    chk("R10 idle pulse", {6'b0, enterSleep, enterIdle}, 8'h01);

    // R11 secondary selected but disabled
    secOscEn = 1'b0;
    regWrite(8'h05);
    step(SW + 1);
    sleepReq = 1'b1;
    step();
    sleepReq = 1'b0;
    chk("R11 rejected idle request", {6'b0, enterSleep, enterIdle}, 8'h00);
    regWrite(8'h01);
    sleepReq = 1'b1;
    step();
    sleepReq = 1'b0;
    chk("R11 rejected sleep request", {6'b0, enterSleep, enterIdle}, 8'h00);
    secOscEn = 1'b1;
    regWrite(8'h05);
    sleepReq = 1'b1;
    step();
    sleepReq = 1'b0;
    chk("R11 accepted when enabled", {6'b0, enterSleep, enterIdle}, 8'h01);

    // R5 primary off clears the timer
    regWrite(8'h00);
    step(SW + 2);
    chk("R6 primary back", {7'b0, priRun}, 8'h01);
    priOscOn = 1'b0;
    step(2);
    chk("R5 timer cleared with oscillator off", {7'b0, priRun}, 8'h00);
    priOscOn = 1'b1;
    step(OST - 2);
    chk("R5 timer restarts from zero", {7'b0, priRun}, 8'h00);

    // R1 reset in mid operation
    regWrite(8'h06);
    step(2);
    rstN = 1'b0;
    #1;
    chk("R1 mid-run reset select", {6'b0, srcSel}, 8'h00);
    chk("R1 mid-run reset register", rdData, 8'h00);
    step();
    rstN = 1'b1;
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule